// File: doc/BRIEF.md
# Radio Burst Identification Detector

This block sits in base-station logic behind a low-power radio receiver. It watches three receiver lines: the recovered serial data, a data clock and a valid-data indicator. All three are asynchronous to the system clock. Every rising edge of the receiver clock shifts one bit into a 24-bit window. A burst is recognised when a fixed 13-bit header lines up at the top of the window while the indicator is high.

An accepted burst gives up its identification byte from the bottom of the window. That byte is shown as two hexadecimal digits on a pair of seven-segment displays and sent to the host as one UART character. The block then goes back to hunting for the next burst.

A silence timer runs while the block is searching and is cleared by every accepted burst. When it saturates it lights an LED, so an operator can tell that the tag has gone quiet. Any burst that completes while a character is still on the wire is dropped, and a sticky flag records the drop.

Top module: `burst_id_reporter`

## Requirements
- R1: After reset `uartTx` is high, both digits show `0`, and `silenceLed` and `overflowFlag` are low.
- R2: Each rising edge of `rxClk`, seen through a two-flop synchroniser, shifts `rxData` into bit 0 of a 24-bit window, and earlier bits move toward bit 23.
- R3: A match needs window bits 23..19 to equal 01010 and bits 18..11 to equal 11011011. A window with either field wrong is not accepted.
- R4: A matching window is accepted only if `rxValid` is high when the match is seen. Otherwise there is no character, the display is unchanged and the silence timer is not cleared.
- R5: An accepted burst captures window bits 7..0. `segHi` shows the upper nibble and `segLo` the lower nibble, in hexadecimal, active low, with output bit 0 driving segment a up to bit 6 driving segment g. The digits hold until the next accepted burst.
- R6: An accepted burst sends the captured byte once on `uartTx` as 8N1: one low start bit, then the data least significant bit first, then one high stop bit. Each bit lasts CLK_HZ/BAUD cycles, and the line idles high.
- R7: A match during a character in flight is dropped: no extra character and no display change. `overflowFlag` sets and stays high until reset.
- R8: While searching, the silence timer counts system cycles. `silenceLed` is high once the count reaches SILENCE_MAX and stays high until an accepted burst clears the count.
- R9: After the stop bit the block searches again and accepts the next matching burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxData | input | 1 | Recovered serial data from the receiver |
| rxClk | input | 1 | Receiver data clock; a rising edge shifts one bit |
| rxValid | input | 1 | Receiver valid-data indicator |
| uartTx | output | 1 | Serial character line to the host, idle high |
| segHi | output | 7 | Active-low segments gfedcba, upper hex digit |
| segLo | output | 7 | Active-low segments gfedcba, lower hex digit |
| silenceLed | output | 1 | High when no burst has been accepted for SILENCE_MAX cycles |
| overflowFlag | output | 1 | Sticky: a burst was dropped during transmission |

## Verification
A rising edge of `rxClk` reaches the window on the third system edge after the pin changes. The capture, the new digits and the start bit all appear on the fourth edge, and the character takes ten bit periods after that. The bench therefore holds `rxValid` for eight cycles after the last data clock edge. It reads the digits only after eleven bit periods plus a margin, and it decodes `uartTx` by sampling each bit in its middle, starting half a period after the start edge is seen. The silence LED is checked 100 cycles before and 100 cycles after the SILENCE_MAX boundary, counted from the end of reset. That keeps the check clear of the single-cycle uncertainty at the boundary.

// File: rtl/burst_rep_pkg.sv
package burst_rep_pkg;

  typedef enum logic {
    SEARCH      = 1'b0,
    COMMUNICATE = 1'b1
  } scanState_e;

  typedef struct packed {
    logic capture;
    logic startTx;
    logic clrTimer;
    logic runTimer;
    logic setOverflow;
  } ctrlStrobe_t;

  // active-low segments, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] hexToSegN(input logic [3:0] nib);
    logic [6:0] s;
    case (nib)
      4'h0: s = 7'h40;
      4'h1: s = 7'h79;
      4'h2: s = 7'h24;
      4'h3: s = 7'h30;
      4'h4: s = 7'h19;
      4'h5: s = 7'h12;
      4'h6: s = 7'h02;
      4'h7: s = 7'h78;
      4'h8: s = 7'h00;
      4'h9: s = 7'h10;
      4'hA: s = 7'h08;
      4'hB: s = 7'h03;
      4'hC: s = 7'h46;
      4'hD: s = 7'h21;
      4'hE: s = 7'h06;
      default: s = 7'h0E;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/burst_rep_ctrl.sv
module burst_rep_ctrl
  import burst_rep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hitPulse,
  input  logic        txDone,
  output ctrlStrobe_t strb
);

  scanState_e state, nextState;

  always_comb begin
    strb          = '0;
    strb.runTimer = (state == SEARCH);
    nextState     = state;
    case (state)
      SEARCH: begin
        if (hitPulse) begin
          strb.capture  = 1'b1;
          strb.startTx  = 1'b1;
          strb.clrTimer = 1'b1;
          nextState     = COMMUNICATE;
        end
      end
      default: begin
        if (hitPulse) strb.setOverflow = 1'b1;
        if (txDone)   nextState = SEARCH;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEARCH;
    else       state <= nextState;
  end

  // R9
  back_to_search_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == COMMUNICATE && txDone) |=> (state == SEARCH));

  // R7
  drop_keeps_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == COMMUNICATE && hitPulse && !txDone) |=> (state == COMMUNICATE && !strb.capture));

endmodule

// File: rtl/burst_rep_datapath.sv
module burst_rep_datapath
  import burst_rep_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned BAUD        = 115_200,
  parameter int unsigned SILENCE_MAX = 375_000_000,
  parameter int unsigned WIN_W       = 24,
  parameter int unsigned HDR_W       = 5,
  parameter int unsigned SYNC_W      = 8,
  parameter int unsigned ID_W        = 8,
  parameter logic [HDR_W-1:0]  HDR_PAT  = 5'b01010,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'b11011011,
  localparam int unsigned DIGITS = ID_W / 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxDataIn,
  input  logic                  rxClkIn,
  input  logic                  rxValidIn,
  input  ctrlStrobe_t           strb,
  output logic                  hitPulse,
  output logic                  txDone,
  output logic                  uartTx,
  output logic [DIGITS-1:0][6:0] segN,
  output logic                  silenceLed,
  output logic                  overflowFlag
);

  localparam int unsigned BAUD_DIV   = CLK_HZ / BAUD;
  localparam int unsigned CNT_W      = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int unsigned FRAME_BITS = ID_W + 2;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned TMR_W      = $clog2(SILENCE_MAX + 1);
  localparam logic [CNT_W-1:0] BAUD_LAST = CNT_W'(BAUD_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [TMR_W-1:0] TMR_TOP   = TMR_W'(SILENCE_MAX);

  // receiver line synchronisers
  logic [1:0] dataSync, clkSync, validSync;
  logic       clkPrev, riseSeen, shiftedQ;
  logic [WIN_W-1:0] window;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSync  <= '0;
      clkSync   <= '0;
      validSync <= '0;
      clkPrev   <= 1'b0;
    end else begin
      dataSync  <= {dataSync[0], rxDataIn};
      clkSync   <= {clkSync[0], rxClkIn};
      validSync <= {validSync[0], rxValidIn};
      clkPrev   <= clkSync[1];
    end
  end

  assign riseSeen = clkSync[1] & ~clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window   <= '0;
      shiftedQ <= 1'b0;
    end else begin
      shiftedQ <= riseSeen;
      if (riseSeen) window <= {window[WIN_W-2:0], dataSync[1]};
    end
  end

  logic hdrOk, syncOk;
  assign hdrOk    = (window[WIN_W-1 -: HDR_W] == HDR_PAT);
  assign syncOk   = (window[WIN_W-HDR_W-1 -: SYNC_W] == SYNC_PAT);
  assign hitPulse = shiftedQ & hdrOk & syncOk & validSync[1];

  // payload and display
  logic [ID_W-1:0] payloadQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             payloadQ <= '0;
    else if (strb.capture) payloadQ <= window[ID_W-1:0];
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign segN[d] = hexToSegN(payloadQ[4*d +: 4]);
  end

  // silence timer
  logic [TMR_W-1:0] silenceCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       silenceCnt <= '0;
    else if (strb.clrTimer)                          silenceCnt <= '0;
    else if (strb.runTimer && silenceCnt != TMR_TOP) silenceCnt <= silenceCnt + 1'b1;
  end
  assign silenceLed = (silenceCnt == TMR_TOP);

  // sticky drop flag
  logic overflowQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 overflowQ <= 1'b0;
    else if (strb.setOverflow) overflowQ <= 1'b1;
  end
  assign overflowFlag = overflowQ;

  // UART transmitter
  logic                  txBusy, uartTxQ;
  logic [CNT_W-1:0]      baudCnt;
  logic [IDX_W-1:0]      bitIdx;
  logic [FRAME_BITS-1:0] txFrame;

  assign txDone = txBusy && (baudCnt == BAUD_LAST) && (bitIdx == IDX_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      uartTxQ <= 1'b1;
      baudCnt <= '0;
      bitIdx  <= '0;
      txFrame <= '1;
    end else if (strb.startTx) begin
      txBusy  <= 1'b1;
      uartTxQ <= 1'b0;
      baudCnt <= '0;
      bitIdx  <= '0;
      txFrame <= {1'b1, window[ID_W-1:0], 1'b0};
    end else if (txBusy) begin
      if (baudCnt == BAUD_LAST) begin
        baudCnt <= '0;
        if (bitIdx == IDX_LAST) begin
          txBusy  <= 1'b0;
          uartTxQ <= 1'b1;
        end else begin
          bitIdx  <= bitIdx + 1'b1;
          txFrame <= {1'b1, txFrame[FRAME_BITS-1:1]};
          uartTxQ <= txFrame[1];
        end
      end else begin
        baudCnt <= baudCnt + 1'b1;
      end
    end
  end
  assign uartTx = uartTxQ;

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startTx |-> !txBusy);

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ |=> overflowQ);

  // R5
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(payloadQ));

  // R8
  led_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (silenceLed && !strb.clrTimer) |=> silenceLed);

  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startTx |=> (!uartTx && txBusy));

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !strb.startTx) |=> uartTx);

endmodule

// File: rtl/burst_id_reporter.sv
module burst_id_reporter
  import burst_rep_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned BAUD        = 115_200,
  parameter int unsigned SILENCE_MAX = 375_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxData,
  input  logic       rxClk,
  input  logic       rxValid,
  output logic       uartTx,
  output logic [6:0] segHi,
  output logic [6:0] segLo,
  output logic       silenceLed,
  output logic       overflowFlag
);

  localparam int unsigned ID_W = 8;

  ctrlStrobe_t strb;
  logic        hitPulse, txDone;
  logic [ID_W/4-1:0][6:0] segN;

  burst_rep_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hitPulse (hitPulse),
    .txDone   (txDone),
    .strb     (strb)
  );

  burst_rep_datapath #(
    .CLK_HZ      (CLK_HZ),
    .BAUD        (BAUD),
    .SILENCE_MAX (SILENCE_MAX),
    .ID_W        (ID_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .rxDataIn     (rxData),
    .rxClkIn      (rxClk),
    .rxValidIn    (rxValid),
    .strb         (strb),
    .hitPulse     (hitPulse),
    .txDone       (txDone),
    .uartTx       (uartTx),
    .segN         (segN),
    .silenceLed   (silenceLed),
    .overflowFlag (overflowFlag)
  );

  assign segHi = segN[1];
  assign segLo = segN[0];

endmodule

// File: tb/burst_id_reporter_tb_top.sv
module burst_id_reporter_tb_top;

  localparam int CLK_HZ  = 125_000_000;
  localparam int BAUD    = 3_125_000;
  localparam int DIV     = CLK_HZ / BAUD;
  localparam int SIL_MAX = 1500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxData = 1'b0, rxClk = 1'b0, rxValid = 1'b0;
  logic uartTx, silenceLed, overflowFlag;
  logic [6:0] segHi, segLo;

  always #4 clk = ~clk;

  burst_id_reporter #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .SILENCE_MAX(SIL_MAX)) dut_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxClk(rxClk), .rxValid(rxValid),
    .uartTx(uartTx), .segHi(segHi), .segLo(segLo),
    .silenceLed(silenceLed), .overflowFlag(overflowFlag)
  );

  int checks = 0;
  int fails  = 0;
  int charCount = 0;
  logic [7:0] lastChar = 8'h00;
  bit done = 0;

  // {word[23:0], valid, accept}
  localparam logic [25:0] VECS [0:5] = '{
    {5'b01010, 8'hDB, 3'b000, 8'hA5, 1'b1, 1'b1},
    {5'b01010, 8'hDB, 3'b000, 8'h3C, 1'b0, 1'b0},
    {5'b01011, 8'hDB, 3'b000, 8'h77, 1'b1, 1'b0},
    {5'b01010, 8'hDA, 3'b000, 8'h12, 1'b1, 1'b0},
    {5'b01010, 8'hDB, 3'b101, 8'h0F, 1'b1, 1'b1},
    {5'b01010, 8'hDB, 3'b011, 8'hE9, 1'b1, 1'b1}
  };

  function automatic logic [6:0] refSeg(input logic [3:0] v);
    logic [6:0] r;
    case (v)
      0: r = 7'b1000000;  1: r = 7'b1111001;  2: r = 7'b0100100;  3: r = 7'b0110000;
      4: r = 7'b0011001;  5: r = 7'b0010010;  6: r = 7'b0000010;  7: r = 7'b1111000;
      8: r = 7'b0000000;  9: r = 7'b0010000; 10: r = 7'b0001000; 11: r = 7'b0000011;
      12: r = 7'b1000110; 13: r = 7'b0100001; 14: r = 7'b0000110; default: r = 7'b0001110;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic d);
    rxData = d;
    waitCyc(2);
    rxClk = 1'b1;
    waitCyc(2);
    rxClk = 1'b0;
  endtask

  task automatic flush();
    rxValid = 1'b0;
    for (int i = 0; i < 24; i++) sendBit(1'b0);
  endtask

  task automatic sendWord(input logic [23:0] w, input logic v);
    rxValid = v;
    for (int i = 23; i >= 0; i--) sendBit(w[i]);
    waitCyc(8);
    rxValid = 1'b0;
  endtask

  // UART monitor, mid-bit sampling
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge uartTx);
      waitCyc(DIV / 2);
      chk("R6 start bit", {31'd0, uartTx}, 32'd0);
      for (int i = 0; i < 8; i++) begin
        waitCyc(DIV);
        b[i] = uartTx;
      end
      waitCyc(DIV);
      chk("R6 stop bit", {31'd0, uartTx}, 32'd1);
      lastChar = b;
      charCount++;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int expChars;
    logic [7:0] expByte;
    expChars = 0;
    expByte  = 8'h00;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    // R1 reset state
    chk("R1 uartTx idle", {31'd0, uartTx}, 32'd1);
    chk("R1 segHi", {25'd0, segHi}, {25'd0, refSeg(4'h0)});
    chk("R1 segLo", {25'd0, segLo}, {25'd0, refSeg(4'h0)});
    chk("R1 led", {31'd0, silenceLed}, 32'd0);
    chk("R1 overflow", {31'd0, overflowFlag}, 32'd0);

    // R8 silence boundary
    waitCyc(SIL_MAX - 100 - 5);
    chk("R8 led before max", {31'd0, silenceLed}, 32'd0);
    waitCyc(200);
    chk("R8 led after max", {31'd0, silenceLed}, 32'd1);

    // stimulus table: R2 R3 R4 R5 R6 R9
    for (int k = 0; k < 6; k++) begin
      flush();
      sendWord(VECS[k][25:2], VECS[k][1]);
      waitCyc(11 * DIV + 30);
      if (VECS[k][0]) begin
        expChars++;
        expByte = VECS[k][9:2];
        chk("R8 led cleared by hit", {31'd0, silenceLed}, 32'd0);
      end
      chk("R2/R3/R4 char count", charCount, expChars);
      chk("R6 char value", {24'd0, lastChar}, {24'd0, expByte});
      chk("R5 segHi", {25'd0, segHi}, {25'd0, refSeg(expByte[7:4])});
      chk("R5 segLo", {25'd0, segLo}, {25'd0, refSeg(expByte[3:0])});
    end
    chk("R7 no overflow yet", {31'd0, overflowFlag}, 32'd0);

    // R7 second burst during transmission
    flush();
    sendWord({5'b01010, 8'hDB, 3'b000, 8'h5A}, 1'b1);
    expChars++;
    flush();
    sendWord({5'b01010, 8'hDB, 3'b000, 8'hC3}, 1'b1);
    chk("R7 overflow set", {31'd0, overflowFlag}, 32'd1);
    waitCyc(12 * DIV + 30);
    chk("R7 one char only", charCount, expChars);
    chk("R7 char is first", {24'd0, lastChar}, 32'h5A);
    chk("R7 segHi unchanged", {25'd0, segHi}, {25'd0, refSeg(4'h5)});
    chk("R7 segLo unchanged", {25'd0, segLo}, {25'd0, refSeg(4'hA)});

    // R9 searches again, overflow still sticky
    flush();
    sendWord({5'b01010, 8'hDB, 3'b000, 8'h66}, 1'b1);
    expChars++;
    waitCyc(11 * DIV + 30);
    chk("R9 next burst accepted", charCount, expChars);
    chk("R9 char value", {24'd0, lastChar}, 32'h66);
    chk("R7 overflow sticky", {31'd0, overflowFlag}, 32'd1);

    finishRun();
  end

endmodule